// File: doc/BRIEF.md
# Vector Register Index Relocation Unit

This block sits in the operand path of a vector pipeline. It moves the vector register numbers of one instruction by a per-wavefront offset. Each instruction has four operand fields: three sources and one destination. A relocation-enable bit in the mode register turns the function on. The M0 register supplies two things: an 8-bit offset, and a four-bit mask that picks which operands get the offset.

For a picked operand, the result is the operand's register number plus the offset. The result becomes register 0 in two cases:
- the sum does not fall below the number of allocated vector registers, or
- the operand does not name a vector register at all.

The result never wraps around.

Results are registered. They appear one clock after an input marked valid, with a valid flag that follows them. Operands that are not picked pass through untouched. The same is true of all operands while the enable bit is clear.

Top module: `vreg_reloc_unit`

## Requirements
- R1: While bit 27 of `mode_reg` is 0, every output operand equals the corresponding input operand, whatever `m0_reg` and `opnd_is_vec` hold.
- R2: The offset is `m0_reg[7:0]`. For a picked operand that names a vector register, the output is the input number plus the offset, as long as that sum is strictly below `vreg_count`.
- R3: Operand i (i = 0, 1, 2 for the sources, 3 for the destination) occupies bits [8i+7:8i] of `opnd_num` and `out_num`. It is picked when bit 27 of `mode_reg` is 1 and `m0_reg[12+i]` is 1. Each mask bit acts on its own operand only.
- R4: For a picked vector operand whose sum is greater than or equal to `vreg_count`, the output is 0. The sum is formed at 9 bits, so for example 255 + 1 with `vreg_count` = 256 gives 0 and not 0 by wrap-around luck. Likewise 250 + 10 gives 0 and not 4.
- R5: A picked operand whose `opnd_is_vec` bit is 0 produces output 0.
- R6: An operand that is not picked passes through unchanged, whether or not its `opnd_is_vec` bit is set.
- R7: `out_valid` is `in_valid` delayed by exactly one clock. `out_num` shows the result for the inputs present at that edge.
- R8: When `in_valid` is 0 at an edge, `out_num` keeps its previous value.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_num` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand fields below are valid this cycle |
| mode_reg | input | 32 | Wavefront mode register; bit 27 enables relocation |
| m0_reg | input | 32 | M0 register; [7:0] offset, [15:12] operand mask |
| opnd_num | input | 32 | Four packed operand register numbers, operand i in [8i+7:8i] |
| opnd_is_vec | input | 4 | Bit i set when operand i names a vector register |
| vreg_count | input | 9 | Number of allocated vector registers (0 to 256) |
| out_valid | output | 1 | Relocated operands valid |
| out_num | output | 32 | Four packed relocated register numbers |

## Verification
The hardest case to reach is the edge of the allocation: a sum that lands exactly on `vreg_count`, or one at `vreg_count` − 1. A close second is a sum that passes 255 while the 8-bit truncation looks small and in range. Uniform random stimulus almost never hits these.

The bench therefore applies directed vectors for both cases:
- a sum of exactly `vreg_count` − 1,
- a sum of exactly `vreg_count`,
- 255 + 1 and 250 + 10 against a full 256-register allocation.

The random phase then biases register numbers and counts toward the top of the range. It also mixes mask patterns, enable values and vector flags, so that every classification of an operand shows up many times, next to its siblings in other classes.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
   // Slot order inside the packed operand buses; the mask bit for slot i
   // sits at SEL_LSB + i.
   typedef enum int unsigned {
      SLOT_SRC0 = 0,
      SLOT_SRC1 = 1,
      SLOT_SRC2 = 2,
      SLOT_DST  = 3
   } vrr_slot_e;

   localparam int unsigned VRR_NUM_SLOTS = 4;

   function automatic int unsigned vrr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/vrr_ctrl_decode.sv
module vrr_ctrl_decode #(
   parameter int unsigned MODE_W  = 32,
   parameter int unsigned M0_W    = 32,
   parameter int unsigned EN_BIT  = 27,
   parameter int unsigned OFS_LSB = 0,
   parameter int unsigned OFS_W   = 8,
   parameter int unsigned SEL_LSB = 12,
   parameter int unsigned NUM_OPS = 4
) (
   input  logic [MODE_W-1:0]  mode_reg,
   input  logic [M0_W-1:0]    m0_reg,
   output logic [OFS_W-1:0]   ofs,
   output logic [NUM_OPS-1:0] pick
);
   if (EN_BIT >= MODE_W) begin : g_bad_en
      $error("vrr_ctrl_decode: EN_BIT outside mode register");
   end
   if (OFS_LSB + OFS_W > M0_W) begin : g_bad_ofs
      $error("vrr_ctrl_decode: offset field outside M0");
   end
   if (SEL_LSB + NUM_OPS > M0_W) begin : g_bad_sel
      $error("vrr_ctrl_decode: select field outside M0");
   end

   logic reloc_on;

   always_comb begin
      reloc_on = mode_reg[EN_BIT];
      ofs      = m0_reg[OFS_LSB +: OFS_W];
      pick     = m0_reg[SEL_LSB +: NUM_OPS] & {NUM_OPS{reloc_on}};
   end
endmodule

// File: rtl/vrr_operand_map.sv
module vrr_operand_map #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned OFS_W = 8
) (
   input  logic             pick,
   input  logic             is_vec,
   input  logic [REG_W-1:0] num_in,
   input  logic [OFS_W-1:0] ofs,
   input  logic [REG_W:0]   vreg_count,
   output logic [REG_W-1:0] num_out
);
   // One bit wider than the wider addend: a carry out is kept, never lost.
   localparam int unsigned SUM_W = vrr_pkg::vrr_max(REG_W, OFS_W) + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] limit;
   logic             fits;

   always_comb begin
      sum   = SUM_W'(num_in) + SUM_W'(ofs);
      limit = SUM_W'(vreg_count);
      fits  = (sum < limit);
      if (!pick)
         num_out = num_in;
      else if (is_vec && fits)
         num_out = sum[REG_W-1:0];
      else
         num_out = '0;
   end
endmodule

// File: rtl/vrr_out_reg.sv
module vrr_out_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] d,
   output logic         out_valid,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         q         <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            q <= d;
      end
   end
endmodule

// File: rtl/vreg_reloc_unit.sv
module vreg_reloc_unit #(
   parameter int unsigned NUM_OPS = vrr_pkg::VRR_NUM_SLOTS,
   parameter int unsigned REG_W   = 8,
   parameter int unsigned MODE_W  = 32,
   parameter int unsigned M0_W    = 32,
   parameter int unsigned EN_BIT  = 27,
   parameter int unsigned OFS_LSB = 0,
   parameter int unsigned OFS_W   = 8,
   parameter int unsigned SEL_LSB = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [MODE_W-1:0]        mode_reg,
   input  logic [M0_W-1:0]          m0_reg,
   input  logic [NUM_OPS*REG_W-1:0] opnd_num,
   input  logic [NUM_OPS-1:0]       opnd_is_vec,
   input  logic [REG_W:0]           vreg_count,
   output logic                     out_valid,
   output logic [NUM_OPS*REG_W-1:0] out_num
);
   localparam int unsigned BUS_W = NUM_OPS * REG_W;

   if (NUM_OPS < 1) begin : g_bad_ops
      $error("vreg_reloc_unit: NUM_OPS must be at least 1");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("vreg_reloc_unit: REG_W must be at least 1");
   end

   logic [OFS_W-1:0]   ofs;
   logic [NUM_OPS-1:0] pick;
   logic [BUS_W-1:0]   mapped;

   vrr_ctrl_decode #(
      .MODE_W (MODE_W),
      .M0_W   (M0_W),
      .EN_BIT (EN_BIT),
      .OFS_LSB(OFS_LSB),
      .OFS_W  (OFS_W),
      .SEL_LSB(SEL_LSB),
      .NUM_OPS(NUM_OPS)
   ) u_decode (
      .mode_reg(mode_reg),
      .m0_reg  (m0_reg),
      .ofs     (ofs),
      .pick    (pick)
   );

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
      vrr_operand_map #(
         .REG_W(REG_W),
         .OFS_W(OFS_W)
      ) u_map (
         .pick      (pick[i]),
         .is_vec    (opnd_is_vec[i]),
         .num_in    (opnd_num[i*REG_W +: REG_W]),
         .ofs       (ofs),
         .vreg_count(vreg_count),
         .num_out   (mapped[i*REG_W +: REG_W])
      );
   end

   vrr_out_reg #(
      .W(BUS_W)
   ) u_oreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .d        (mapped),
      .out_valid(out_valid),
      .q        (out_num)
   );
endmodule

// File: rtl/vrr_checker.sv
module vrr_checker #(
   parameter int unsigned NUM_OPS = 4,
   parameter int unsigned REG_W   = 8,
   parameter int unsigned MODE_W  = 32,
   parameter int unsigned M0_W    = 32,
   parameter int unsigned EN_BIT  = 27,
   parameter int unsigned SEL_LSB = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [MODE_W-1:0]        mode_reg,
   input logic [M0_W-1:0]          m0_reg,
   input logic [NUM_OPS*REG_W-1:0] opnd_num,
   input logic [NUM_OPS-1:0]       opnd_is_vec,
   input logic [REG_W:0]           vreg_count,
   input logic                     out_valid,
   input logic [NUM_OPS*REG_W-1:0] out_num
);
   a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_num));

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      a_r1_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !mode_reg[EN_BIT]
         |=> out_num[i*REG_W +: REG_W] == $past(opnd_num[i*REG_W +: REG_W]));
      a_r6_unpicked_passthru: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !m0_reg[SEL_LSB+i]
         |=> out_num[i*REG_W +: REG_W] == $past(opnd_num[i*REG_W +: REG_W]));
      a_r5_nonvec_zero: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && mode_reg[EN_BIT] && m0_reg[SEL_LSB+i] && !opnd_is_vec[i]
         |=> out_num[i*REG_W +: REG_W] == '0);
      a_r4_within_alloc: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && mode_reg[EN_BIT] && m0_reg[SEL_LSB+i]
         |=> (out_num[i*REG_W +: REG_W] == '0) ||
             ({1'b0, out_num[i*REG_W +: REG_W]} < $past(vreg_count)));
   end
endmodule

bind vreg_reloc_unit vrr_checker #(
   .NUM_OPS(NUM_OPS),
   .REG_W  (REG_W),
   .MODE_W (MODE_W),
   .M0_W   (M0_W),
   .EN_BIT (EN_BIT),
   .SEL_LSB(SEL_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .mode_reg   (mode_reg),
   .m0_reg     (m0_reg),
   .opnd_num   (opnd_num),
   .opnd_is_vec(opnd_is_vec),
   .vreg_count (vreg_count),
   .out_valid  (out_valid),
   .out_num    (out_num)
);

// File: tb/vreg_reloc_unit_tb.sv
module vreg_reloc_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NOPS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] mode_reg = '0;
   logic [31:0] m0_reg = '0;
   logic [31:0] opnd_num = '0;
   logic [3:0]  opnd_is_vec = '0;
   logic [8:0]  vreg_count = '0;
   logic        out_valid;
   logic [31:0] out_num;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vreg_reloc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_reg(mode_reg),
      .m0_reg(m0_reg), .opnd_num(opnd_num), .opnd_is_vec(opnd_is_vec),
      .vreg_count(vreg_count), .out_valid(out_valid), .out_num(out_num)
   );

   // Expected value of slot i, from the requirements.
   function automatic logic [7:0] exp_slot(input logic [31:0] md, input logic [31:0] m0,
                                           input logic [7:0] n, input logic v,
                                           input logic [8:0] cnt, input int i);
      int s;
      if (!md[27] || !m0[12+i]) return n;
      if (!v) return 8'd0;
      s = int'(n) + int'(m0[7:0]);
      if (s >= int'(cnt)) return 8'd0;
      return s[7:0];
   endfunction

   function automatic string tag_slot(input logic [31:0] md, input logic [31:0] m0,
                                      input logic [7:0] n, input logic v,
                                      input logic [8:0] cnt, input int i);
      if (!md[27]) return "R1";
      if (!m0[12+i]) return "R6";
      if (!v) return "R5";
      if (int'(n) + int'(m0[7:0]) >= int'(cnt)) return "R4";
      return "R2/R3";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one valid vector, wait for the register, check every slot (R7 latency).
   task automatic apply(input logic [31:0] md, input logic [31:0] m0, input logic [31:0] nums,
                        input logic [3:0] vec, input logic [8:0] cnt);
      logic [7:0] e [NOPS];
      string      t [NOPS];
      @(negedge clk);
      mode_reg = md; m0_reg = m0; opnd_num = nums; opnd_is_vec = vec; vreg_count = cnt;
      in_valid = 1'b1;
      for (int i = 0; i < NOPS; i++) begin
         e[i] = exp_slot(md, m0, nums[i*8 +: 8], vec[i], cnt, i);
         t[i] = tag_slot(md, m0, nums[i*8 +: 8], vec[i], cnt, i);
      end
      @(negedge clk);
      check("R7 valid", {31'd0, out_valid}, 32'd1);
      for (int i = 0; i < NOPS; i++)
         check(t[i], {24'd0, out_num[i*8 +: 8]}, {24'd0, e[i]});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'h5eed_1234));
      // R9: reset state
      #(CLK_PERIOD * 2 + 1);
      check("R9 out_valid", {31'd0, out_valid}, 32'd0);
      check("R9 out_num", out_num, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: disabled, mask full and non-vector flags: everything passes
      apply(32'h0000_0000, 32'h0000_F005, 32'hFF10_2030, 4'b0000, 9'd64);
      // R2/R3: enabled, all picked, in range
      apply(32'h0800_0000, 32'h0000_F004, 32'h0302_0100, 4'b1111, 9'd64);
      // R3: only source 1 picked
      apply(32'h0800_0000, 32'h0000_2010, 32'h0A0B_0C0D, 4'b1111, 9'd128);
      // R3: only destination picked
      apply(32'h0800_0000, 32'h0000_8001, 32'h0A0B_0C0D, 4'b1111, 9'd128);
      // R4: sum exactly count-1 kept, exactly count dropped
      apply(32'h0800_0000, 32'h0000_3005, 32'h0000_3B3A, 4'b1111, 9'd64);
      // R4: 9-bit sum past 255 with full allocation
      apply(32'h0800_0000, 32'h0000_F001, 32'h00FA_FEFF, 4'b1111, 9'd256);
      apply(32'h0800_0000, 32'h0000_F00A, 32'h00FA_FEFA, 4'b1111, 9'd256);
      // R5 and R6: mixed vector flags, picked and not picked
      apply(32'h0800_0000, 32'h0000_5003, 32'h0807_0605, 4'b0000, 9'd200);
      apply(32'h0800_0000, 32'h0000_A003, 32'h0807_0605, 4'b0101, 9'd200);

      // R8: idle cycle with different data, output must hold
      held = out_num;
      @(negedge clk);
      in_valid = 1'b0;
      opnd_num = 32'h5555_5555;
      m0_reg   = 32'h0000_0000;
      @(negedge clk);
      check("R8 hold", out_num, held);
      check("R7 idle valid", {31'd0, out_valid}, 32'd0);

      // Random phase, biased toward the top of the range
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] md, m0, nums;
         logic [3:0]  vec;
         logic [8:0]  cnt;
         md   = ($urandom % 4 != 0) ? 32'h0800_0000 : ($urandom & 32'hF7FF_FFFF);
         m0   = $urandom;
         if ($urandom % 2 == 0) m0[7:0] = 8'(($urandom % 8));
         nums = $urandom;
         if ($urandom % 3 == 0) nums = nums | 32'hC0C0_C0C0;
         vec  = 4'($urandom);
         cnt  = ($urandom % 3 == 0) ? 9'd256 : 9'($urandom % 257);
         apply(md, m0, nums, vec, cnt);
         if ($urandom % 8 == 0) begin
            held = out_num;
            @(negedge clk);
            in_valid = 1'b0;
            opnd_num = $urandom;
            @(negedge clk);
            check("R8 hold", out_num, held);
         end
      end

      // R9: reset again mid-run
      @(negedge clk);
      in_valid = 1'b1;
      rst_n = 1'b0;
      #1;
      check("R9 out_valid", {31'd0, out_valid}, 32'd0);
      check("R9 out_num", out_num, 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule